// File: doc/BRIEF.md
# Li-ion Charge Sequencer

This block is the control core of a switching battery charger for one- or two-cell lithium packs. It takes digital comparator decisions about the battery, such as voltage against the precharge and recharge levels, whether the charge current has fallen to the termination level, battery presence, temperature in window, input power health, overvoltage and the safety-timer timeouts. From these it decides whether the power stage runs and in which current regime. It also drives the safety timer's reset and halt controls and a two-line status code meant for LEDs or a host.

A cycle begins with a qualification step that clears the timer. Depending on the battery voltage, the cycle then enters one of three states: a fixed low-current linear recovery mode, a trickle mode at the programmed precharge current, or fast charge. Fast charge ends when the current stays below the termination level for a number of slow ticks, and the block then reports full. If the battery sags below the recharge level for a deglitched interval, a fresh cycle starts. A battery that is too hot or too cold pauses charging with the timer frozen. A timeout or battery overvoltage latches a fault, which only a loss of input power or an enable toggle can clear.

Top module: `li_charge_fsm`

## Requirements
- R1: Status lines (stat_a, stat_b) encode: 0,0 charging (linear, trickle or fast); 0,1 full; 1,0 fault; 1,1 suspend or idle. stat is 0,0 exactly when chg_on is 1. After reset the block is idle: chg_on 0, chg_mode 0, tmr_reset 1, tmr_halt 0, stat 1,1.
- R2: chg_mode encodes 2'b01 linear (battery below the low threshold), 2'b10 trickle (between the low and high thresholds), 2'b11 fast (above the high threshold) and 2'b00 whenever the charger is off. Entry from idle picks the mode from the two voltage flags.
- R3: In linear or trickle, the mode follows the voltage flags on the next cycle. Trickle falls back to linear if the low flag drops, and either state moves to fast once the high flag is set.
- R4: tmo_pre while in linear or trickle, or tmo_full while in fast, moves the block to fault on the next cycle.
- R5: bat_ovp with power good, no input overvoltage and enable low forces fault from any state on the next cycle.
- R6: pwr_good low or in_ovp high returns the block to idle with the charger off on the next cycle. This also clears a fault.
- R7: Fault persists while power stays good and enable stays low. It ignores battery removal and the clearing of the timeout.
- R8: en_n high forces idle. The enable low cycle that follows starts a new cycle with the timer reset.
- R9: A temperature outside the window in linear, trickle, fast or idle leads to suspend: charger off, tmr_halt 1, stat 1,1. When the temperature returns, the block re-enters the mode chosen by the voltage flags, with tmr_halt 0 and without a timer reset.
- R10: Fast charge terminates to full (charger off, tmr_halt 1) only after ibat_lt_eoc has stayed high for EOC_TICKS tick pulses. Any cycle with the flag low restarts the count.
- R11: In full, vbat_lt_rechg held for RECHG_TICKS tick pulses sends the block to idle for one cycle (tmr_reset 1), then on to a new charge.
- R12: On a trickle or linear to fast transition, tmr_reset pulses for one cycle when FAST_TIMER_RESET is 1. It stays 0 when FAST_TIMER_RESET is 0.
- R13: Battery removal outside fault returns the block to idle. Reinsertion starts a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow time-base enable for the deglitch counters |
| en_n | input | 1 | Charger enable, active low |
| pwr_good | input | 1 | Input supply healthy |
| in_ovp | input | 1 | Input overvoltage |
| bat_ovp | input | 1 | Battery output overvoltage |
| bat_present | input | 1 | Battery detected |
| temp_ok | input | 1 | Battery temperature inside the charging window |
| vbat_gt_lo | input | 1 | Battery above the low precharge threshold |
| vbat_gt_hi | input | 1 | Battery above the fast-charge threshold |
| vbat_lt_rechg | input | 1 | Battery below the recharge threshold |
| ibat_lt_eoc | input | 1 | Charge current below the termination level |
| tmo_pre | input | 1 | Precharge timeout from the safety timer |
| tmo_full | input | 1 | Total charge timeout from the safety timer |
| chg_on | output | 1 | Power stage enabled |
| chg_mode | output | 2 | Current regime: off, linear, trickle, fast |
| tmr_reset | output | 1 | Clear the safety timer |
| tmr_halt | output | 1 | Freeze the safety timer |
| stat_a | output | 1 | Status line A |
| stat_b | output | 1 | Status line B |

## Verification
The bench goes after the deglitch boundaries. It checks termination one tick short of the limit and after an interrupted run, where a design counting total rather than consecutive ticks would report full too early. It checks that fault stays latched when the battery is pulled and the timeout clears, which a design that reused the idle path for removal would drop. It checks that resuming from suspend does not clear the timer, while entering fast charge does so only in the two-cell setting. Random phases with biased input mixes confirm that power loss, overvoltage and temperature each win over the charging states, and that the status code never disagrees with the charger enable.

// File: rtl/cc_pkg.sv
package cc_pkg;

  localparam int ST_IDLE  = 0;
  localparam int ST_LIN   = 1;
  localparam int ST_TRK   = 2;
  localparam int ST_FAST  = 3;
  localparam int ST_FULL  = 4;
  localparam int ST_SUSP  = 5;
  localparam int ST_FAULT = 6;
  localparam int NUM_ST   = 7;

  typedef logic [NUM_ST-1:0] state_t;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_LIN  = 2'b01,
    MODE_TRK  = 2'b10,
    MODE_FAST = 2'b11
  } mode_e;

  function automatic state_t st_bit(input int idx);
    state_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // Pick the charging regime from the two voltage comparators
  function automatic state_t qualify(input logic gt_lo, input logic gt_hi);
    if (!gt_lo)      return st_bit(ST_LIN);
    else if (!gt_hi) return st_bit(ST_TRK);
    else             return st_bit(ST_FAST);
  endfunction

endpackage

// File: rtl/cc_deglitch.sv
module cc_deglitch #(
  parameter int TICKS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  input  logic cond,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS);

  logic [CW-1:0] cnt_q;
  logic          clr;
  logic          inc_en;

  assign clr    = !arm || !cond;
  assign inc_en = tick && (cnt_q != LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = arm && cond && (cnt_q == LIMIT);

endmodule

// File: rtl/cc_next_state.sv
module cc_next_state
  import cc_pkg::*;
(
  input  state_t state_q,
  input  logic   en_n,
  input  logic   pwr_good,
  input  logic   in_ovp,
  input  logic   bat_ovp,
  input  logic   bat_present,
  input  logic   temp_ok,
  input  logic   vbat_gt_lo,
  input  logic   vbat_gt_hi,
  input  logic   tmo_pre,
  input  logic   tmo_full,
  input  logic   eoc_done,
  input  logic   rechg_done,
  output state_t state_d
);
  logic   pwr_ok;
  state_t pick;

  assign pwr_ok = pwr_good && !in_ovp;
  assign pick   = qualify(vbat_gt_lo, vbat_gt_hi);

  always_comb begin
    state_d = state_q;
    if (!pwr_ok || en_n) begin
      state_d = st_bit(ST_IDLE);
    end else if (bat_ovp || state_q[ST_FAULT]) begin
      state_d = st_bit(ST_FAULT);
    end else if (!bat_present) begin
      state_d = st_bit(ST_IDLE);
    end else if (state_q[ST_IDLE]) begin
      state_d = temp_ok ? pick : st_bit(ST_SUSP);
    end else if (state_q[ST_LIN] || state_q[ST_TRK]) begin
      if (!temp_ok)     state_d = st_bit(ST_SUSP);
      else if (tmo_pre) state_d = st_bit(ST_FAULT);
      else              state_d = pick;
    end else if (state_q[ST_FAST]) begin
      if (!temp_ok)      state_d = st_bit(ST_SUSP);
      else if (tmo_full) state_d = st_bit(ST_FAULT);
      else if (eoc_done) state_d = st_bit(ST_FULL);
    end else if (state_q[ST_FULL]) begin
      if (rechg_done) state_d = st_bit(ST_IDLE);
    end else if (state_q[ST_SUSP]) begin
      if (temp_ok) state_d = pick;
    end
  end

endmodule

// File: rtl/li_charge_fsm.sv
module li_charge_fsm
  import cc_pkg::*;
#(
  parameter int EOC_TICKS        = 25,
  parameter int RECHG_TICKS      = 25,
  parameter bit FAST_TIMER_RESET = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en_n,
  input  logic       pwr_good,
  input  logic       in_ovp,
  input  logic       bat_ovp,
  input  logic       bat_present,
  input  logic       temp_ok,
  input  logic       vbat_gt_lo,
  input  logic       vbat_gt_hi,
  input  logic       vbat_lt_rechg,
  input  logic       ibat_lt_eoc,
  input  logic       tmo_pre,
  input  logic       tmo_full,
  output logic       chg_on,
  output logic [1:0] chg_mode,
  output logic       tmr_reset,
  output logic       tmr_halt,
  output logic       stat_a,
  output logic       stat_b
);
  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  state_t state_q, state_d;
  logic   eoc_done, rechg_done;

  cc_deglitch #(.TICKS(EOC_TICKS)) u_eoc_dg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick),
    .arm   (state_q[ST_FAST]),
    .cond  (ibat_lt_eoc),
    .done  (eoc_done)
  );

  cc_deglitch #(.TICKS(RECHG_TICKS)) u_rechg_dg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick),
    .arm   (state_q[ST_FULL]),
    .cond  (vbat_lt_rechg),
    .done  (rechg_done)
  );

  cc_next_state u_ns (
    .state_q     (state_q),
    .en_n        (en_n),
    .pwr_good    (pwr_good),
    .in_ovp      (in_ovp),
    .bat_ovp     (bat_ovp),
    .bat_present (bat_present),
    .temp_ok     (temp_ok),
    .vbat_gt_lo  (vbat_gt_lo),
    .vbat_gt_hi  (vbat_gt_hi),
    .tmo_pre     (tmo_pre),
    .tmo_full    (tmo_full),
    .eoc_done    (eoc_done),
    .rechg_done  (rechg_done),
    .state_d     (state_d)
  );

  // Output decode from the next state so outputs line up with state_q
  mode_e mode_d;
  logic  chg_on_d, tmr_reset_d, tmr_halt_d, stat_a_d, stat_b_d;
  logic  from_pre;

  always_comb begin
    if (state_d[ST_LIN])       mode_d = MODE_LIN;
    else if (state_d[ST_TRK])  mode_d = MODE_TRK;
    else if (state_d[ST_FAST]) mode_d = MODE_FAST;
    else                       mode_d = MODE_OFF;
  end

  assign from_pre    = state_q[ST_LIN] || state_q[ST_TRK];
  assign chg_on_d    = state_d[ST_LIN] || state_d[ST_TRK] || state_d[ST_FAST];
  assign tmr_reset_d = state_d[ST_IDLE] ||
                       (FAST_TIMER_RESET && state_d[ST_FAST] && from_pre);
  assign tmr_halt_d  = state_d[ST_SUSP] || state_d[ST_FAULT] || state_d[ST_FULL];
  assign stat_a_d    = state_d[ST_FAULT] || state_d[ST_SUSP] || state_d[ST_IDLE];
  assign stat_b_d    = state_d[ST_FULL]  || state_d[ST_SUSP] || state_d[ST_IDLE];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= st_bit(ST_IDLE);
      chg_on    <= 1'b0;
      chg_mode  <= MODE_OFF;
      tmr_reset <= 1'b1;
      tmr_halt  <= 1'b0;
      stat_a    <= 1'b1;
      stat_b    <= 1'b1;
    end else begin
      state_q   <= state_d;
      chg_on    <= chg_on_d;
      chg_mode  <= mode_d;
      tmr_reset <= tmr_reset_d;
      tmr_halt  <= tmr_halt_d;
      stat_a    <= stat_a_d;
      stat_b    <= stat_b_d;
    end
  end

endmodule

// File: rtl/cc_fsm_chk.sv
module cc_fsm_chk
  import cc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       en_n,
  input logic       pwr_good,
  input logic       in_ovp,
  input logic       bat_ovp,
  input logic       temp_ok,
  input logic       chg_on,
  input logic [1:0] chg_mode,
  input logic       tmr_halt,
  input logic       stat_a,
  input logic       stat_b,
  input state_t     state_q
);

  assert_state_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state_q));

  assert_charging_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chg_on |-> (!stat_a && !stat_b && chg_mode != 2'b00));

  assert_off_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_on |-> (chg_mode == 2'b00));

  assert_power_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good || in_ovp || en_n) |=> (!chg_on && stat_a && stat_b));

  assert_ovp_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && !in_ovp && !en_n && bat_ovp) |=> (stat_a && !stat_b && !chg_on));

  assert_fault_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_a && !stat_b && pwr_good && !in_ovp && !en_n) |=> (stat_a && !stat_b));

  assert_temp_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_ok |=> !chg_on);

  assert_halt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_halt |-> !chg_on);

endmodule

bind li_charge_fsm cc_fsm_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .en_n     (en_n),
  .pwr_good (pwr_good),
  .in_ovp   (in_ovp),
  .bat_ovp  (bat_ovp),
  .temp_ok  (temp_ok),
  .chg_on   (chg_on),
  .chg_mode (chg_mode),
  .tmr_halt (tmr_halt),
  .stat_a   (stat_a),
  .stat_b   (stat_b),
  .state_q  (state_q)
);

// File: tb/li_charge_fsm_tb.sv
`timescale 1ns/1ps
module li_charge_fsm_tb;

  localparam int EOC_T = 4;
  localparam int RCH_T = 3;

  localparam int E_IDLE = 0, E_LIN = 1, E_TRK = 2, E_FAST = 3,
                 E_FULL = 4, E_SUSP = 5, E_FAULT = 6;

  logic clk = 1'b0;
  logic rst_n, tick, en_n, pwr_good, in_ovp, bat_ovp, bat_present, temp_ok;
  logic vbat_gt_lo, vbat_gt_hi, vbat_lt_rechg, ibat_lt_eoc, tmo_pre, tmo_full;
  logic       chg_on, tmr_reset, tmr_halt, stat_a, stat_b;
  logic [1:0] chg_mode;
  logic       chg_on1, tmr_reset1, tmr_halt1, stat_a1, stat_b1;
  logic [1:0] chg_mode1;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  li_charge_fsm #(.EOC_TICKS(EOC_T), .RECHG_TICKS(RCH_T), .FAST_TIMER_RESET(1'b1)) u_dut (
    .clk, .rst_n, .tick, .en_n, .pwr_good, .in_ovp, .bat_ovp, .bat_present,
    .temp_ok, .vbat_gt_lo, .vbat_gt_hi, .vbat_lt_rechg, .ibat_lt_eoc,
    .tmo_pre, .tmo_full, .chg_on, .chg_mode, .tmr_reset, .tmr_halt,
    .stat_a, .stat_b
  );

  li_charge_fsm #(.EOC_TICKS(EOC_T), .RECHG_TICKS(RCH_T), .FAST_TIMER_RESET(1'b0)) u_dut1 (
    .clk, .rst_n, .tick, .en_n, .pwr_good, .in_ovp, .bat_ovp, .bat_present,
    .temp_ok, .vbat_gt_lo, .vbat_gt_hi, .vbat_lt_rechg, .ibat_lt_eoc,
    .tmo_pre, .tmo_full, .chg_on(chg_on1), .chg_mode(chg_mode1),
    .tmr_reset(tmr_reset1), .tmr_halt(tmr_halt1), .stat_a(stat_a1), .stat_b(stat_b1)
  );

  // Expected {chg_on, mode[1:0], tmr_reset, tmr_halt, stat_a, stat_b}
  function automatic logic [6:0] expect_out(input int ph, input bit trst);
    case (ph)
      E_IDLE:  return 7'b0_00_1_0_11;
      E_LIN:   return {1'b1, 2'b01, trst, 1'b0, 2'b00};
      E_TRK:   return {1'b1, 2'b10, trst, 1'b0, 2'b00};
      E_FAST:  return {1'b1, 2'b11, trst, 1'b0, 2'b00};
      E_FULL:  return 7'b0_00_0_1_01;
      E_SUSP:  return 7'b0_00_0_1_11;
      default: return 7'b0_00_0_1_10;
    endcase
  endfunction

  function automatic logic [6:0] observed();
    return {chg_on, chg_mode, tmr_reset, tmr_halt, stat_a, stat_b};
  endfunction

  task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_ph(input string req, input int ph, input bit trst);
    chk(req, observed(), expect_out(ph, trst));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; tick = 1'b0; en_n = 1'b0; pwr_good = 1'b1; in_ovp = 1'b0;
    bat_ovp = 1'b0; bat_present = 1'b1; temp_ok = 1'b1; vbat_gt_lo = 1'b0;
    vbat_gt_hi = 1'b0; vbat_lt_rechg = 1'b0; ibat_lt_eoc = 1'b0;
    tmo_pre = 1'b0; tmo_full = 1'b0;
    cyc(3);
    chk_ph("R1 reset idle", E_IDLE, 1'b0);
    rst_n = 1'b1;
    cyc(3);
    chk_ph("R2 linear entry", E_LIN, 1'b0);

    vbat_gt_lo = 1'b1; cyc(1);
    chk_ph("R3 linear to trickle", E_TRK, 1'b0);
    vbat_gt_hi = 1'b1; cyc(1);
    chk_ph("R12 fast entry resets timer", E_FAST, 1'b1);
    chk("R12 one-cell variant keeps timer", {7'(tmr_reset1)}, 7'd0);
    cyc(1);
    chk_ph("R12 reset is a single pulse", E_FAST, 1'b0);

    temp_ok = 1'b0; cyc(1);
    chk_ph("R9 suspend on temperature", E_SUSP, 1'b0);
    temp_ok = 1'b1; cyc(1);
    chk_ph("R9 resume without timer reset", E_FAST, 1'b0);

    // R10: an interrupted run must restart the count
    ibat_lt_eoc = 1'b1;
    repeat (EOC_T - 1) one_tick();
    ibat_lt_eoc = 1'b0; cyc(1);
    ibat_lt_eoc = 1'b1;
    repeat (EOC_T - 1) one_tick();
    cyc(1);
    chk_ph("R10 one tick short stays fast", E_FAST, 1'b0);
    one_tick(); cyc(1);
    chk_ph("R10 termination to full", E_FULL, 1'b0);
    ibat_lt_eoc = 1'b0;

    vbat_lt_rechg = 1'b1;
    repeat (RCH_T - 1) one_tick();
    cyc(1);
    chk_ph("R11 recharge not yet", E_FULL, 1'b0);
    one_tick(); cyc(1);
    chk_ph("R11 recharge restarts via idle", E_IDLE, 1'b0);
    vbat_lt_rechg = 1'b0; cyc(1);
    chk_ph("R11 new fast charge", E_FAST, 1'b0);

    tmo_full = 1'b1; cyc(1);
    chk_ph("R4 total timeout fault", E_FAULT, 1'b0);
    tmo_full = 1'b0; bat_present = 1'b0; cyc(5);
    chk_ph("R7 fault held", E_FAULT, 1'b0);
    bat_present = 1'b1;

    en_n = 1'b1; cyc(1);
    chk_ph("R8 enable high idles", E_IDLE, 1'b0);
    en_n = 1'b0; cyc(1);
    chk_ph("R8 enable low new cycle", E_FAST, 1'b0);

    bat_present = 1'b0; cyc(1);
    chk_ph("R13 removal idles", E_IDLE, 1'b0);
    bat_present = 1'b1; vbat_gt_hi = 1'b0; cyc(1);
    chk_ph("R13 reinsertion trickle", E_TRK, 1'b0);
    vbat_gt_lo = 1'b0; cyc(1);
    chk_ph("R3 trickle falls back to linear", E_LIN, 1'b0);
    vbat_gt_lo = 1'b1; cyc(1);
    tmo_pre = 1'b1; cyc(1);
    chk_ph("R4 precharge timeout fault", E_FAULT, 1'b0);
    tmo_pre = 1'b0;
    pwr_good = 1'b0; cyc(1);
    chk_ph("R6 power loss idles", E_IDLE, 1'b0);
    pwr_good = 1'b1; cyc(1);
    chk_ph("R6 fault cleared by power cycle", E_TRK, 1'b0);

    vbat_gt_hi = 1'b1; cyc(1);
    chk_ph("R12 trickle to fast resets timer", E_FAST, 1'b1);
    chk("R12 variant no reset on fast", {7'(tmr_reset1)}, 7'd0);
    in_ovp = 1'b1; cyc(1);
    chk_ph("R6 input overvoltage stops", E_IDLE, 1'b0);
    in_ovp = 1'b0; cyc(1);
    bat_ovp = 1'b1; cyc(1);
    chk_ph("R5 battery overvoltage fault", E_FAULT, 1'b0);
    bat_ovp = 1'b0; en_n = 1'b1; cyc(1); en_n = 1'b0; cyc(1);

    // Biased random phase
    for (int i = 0; i < 3000; i++) begin
      pwr_good      = ($urandom_range(0, 99) < 95);
      in_ovp        = ($urandom_range(0, 99) < 3);
      en_n          = ($urandom_range(0, 99) < 4);
      bat_ovp       = ($urandom_range(0, 99) < 2);
      bat_present   = ($urandom_range(0, 99) < 97);
      temp_ok       = ($urandom_range(0, 99) < 90);
      vbat_gt_lo    = ($urandom_range(0, 99) < 80);
      vbat_gt_hi    = ($urandom_range(0, 99) < 60);
      vbat_lt_rechg = ($urandom_range(0, 99) < 30);
      ibat_lt_eoc   = ($urandom_range(0, 99) < 60);
      tmo_pre       = ($urandom_range(0, 99) < 2);
      tmo_full      = ($urandom_range(0, 99) < 1);
      tick          = ($urandom_range(0, 99) < 50);
      cyc(1);
      if (!pwr_good || in_ovp || en_n)
        chk("R6 random off", {chg_on, stat_a, stat_b, 4'b0}, {3'b011, 4'b0});
      else if (bat_ovp)
        chk("R5 random fault", {stat_a, stat_b, 5'b0}, {2'b10, 5'b0});
      else if (!temp_ok)
        chk("R9 random temp", {6'b0, chg_on}, 7'd0);
      chk("R1 random code", {6'b0, chg_on}, {6'b0, (!stat_a && !stat_b)});
      chk("R2 random mode", {6'b0, chg_on}, {6'b0, (chg_mode != 2'b00)});
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule